// File: doc/BRIEF.md
# I2C High-Speed Entry Master

This block is a byte-level I2C master that can lift a transfer into high-speed signalling. A launch command carries a master code. The block puts a START on the idle bus and shifts the code out at the slow timing that was configured, which may be standard, fast or fast-plus. It then reads the ninth bit. A released SDA on that bit is the normal outcome, and a pulled-low SDA is reported as a protocol error. After that the SCL generator changes to a low/high ratio of 2:1 on its own. The next byte command is preceded by a repeated START without being asked for. Every byte up to the STOP runs at the high-speed rate.

One SCL period lasts 2*(1+period)*(low units + high units) system clocks. Slow timing uses `tpr_i` with the low/high unit counts set by parameters. High-speed timing uses `hs_tpr_i` with 2 low units and 1 high unit, but only while `hs_tpr_en_i` is set. With a 200 MHz clock and a period value of 9, one high-speed bit takes 60 clocks, which is 3.33 MHz. A STOP always returns the block to slow timing.

Commands are taken only while `ready_o` is high. A launch comes in two kinds. In the single kind, the first high-speed byte is closed with a STOP on its own. In the burst kind, bytes continue until a command asks for a STOP.

Top module: `i2c_hs_master`

## Requirements
- R1: After reset, both open-drain enables are low. `ready_o` is 1 and `busy_o` is 0. `hs_mode_o`, `nack_o`, `code_err_o` and `proto_err_o` are all 0.
- R2: A launch (`cmd_hs_i`=1) is accepted only if bits [7:3] of its code equal 5'b00001. Any other code sets `code_err_o`, causes no bus activity and leaves `ready_o` high. Any accepted command clears `code_err_o`.
- R3: The master code is sent at slow timing. SCL low lasts 2*(tpr_i+1)*SLOW_LP clocks and SCL high lasts 2*(tpr_i+1)*SLOW_HP clocks.
- R4: On the ninth bit of the master code, SDA high is accepted without an error. SDA low sets `proto_err_o`, and the block still enters high-speed mode.
- R5: After the master code, `hs_mode_o` is 1. The next byte command starts with a repeated START even if `cmd_start_i`=0. Its bits use low = 4*(hs_tpr_i+1) and high = 2*(hs_tpr_i+1) clocks.
- R6: In a burst launch, every later byte command runs at high-speed timing without `cmd_hs_i`, until a command with `cmd_stop_i`=1 completes.
- R7: The end of a STOP clears `hs_mode_o`. Both lines are then released, and the next START and bytes use slow timing.
- R8: While `hs_tpr_en_i`=0, bytes sent in high-speed mode use slow timing lengths.
- R9: A command presented while `busy_o`=1 is ignored. It adds no bits on the bus and does not change the byte being sent.
- R10: A read byte leaves SDA released for 8 bits and samples them MSB first into `rx_data_o`. On the ninth bit the block pulls SDA low if `cmd_ack_i`=1 and leaves it released otherwise.
- R11: A written slave byte whose ninth bit reads SDA high sets `nack_o`.
- R12: After a single launch (`cmd_burst_i`=0), the first high-speed byte ends with a STOP even when `cmd_stop_i`=0. Afterwards `hs_mode_o` is 0 and both lines are released.
- R13: SCL changes level only when a timed phase ends or when a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tpr_i | input | TPR_W | Slow-rate timer period |
| hs_tpr_i | input | TPR_W | High-speed timer period |
| hs_tpr_en_i | input | 1 | Use the high-speed period and 2:1 ratio in high-speed mode |
| cmd_valid_i | input | 1 | Command strobe, taken while ready_o is high |
| cmd_start_i | input | 1 | Precede the byte with a START or repeated START |
| cmd_stop_i | input | 1 | Follow the byte with a STOP |
| cmd_hs_i | input | 1 | Launch: cmd_data_i is a master code |
| cmd_burst_i | input | 1 | Launch kind: 1 burst, 0 single |
| cmd_read_i | input | 1 | Read a byte instead of writing |
| cmd_ack_i | input | 1 | Acknowledge a read byte |
| cmd_data_i | input | 8 | Byte to write or master code |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| ready_o | output | 1 | Idle or holding the bus, ready for a command |
| busy_o | output | 1 | Command in progress |
| hs_mode_o | output | 1 | High-speed session active |
| rx_data_o | output | 8 | Last byte read |
| nack_o | output | 1 | Slave did not acknowledge the last written byte |
| code_err_o | output | 1 | Last launch code rejected |
| proto_err_o | output | 1 | Master code was acknowledged |

## Verification
The bench uses the default build: TPR_W=8, SLOW_LP=6 and SLOW_HP=4. It drives tpr_i=1 and hs_tpr_i=0, so a slow bit is 24 low plus 16 high clocks and a high-speed bit is 4 low plus 2 high clocks. These short phases let a modelled slave on SDA measure the length of every SCL pulse across a master code, a repeated START, a run of high-speed bytes and a STOP, all within a few thousand cycles. Clearing hs_tpr_en_i for one session checks the fallback to slow timing. A single launch with an acknowledged code checks both the protocol error and the forced STOP.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;
  localparam int BYTE_W   = 8;
  localparam int HS_LP    = 2;
  localparam int HS_HP    = 1;
  localparam int PREFIX_W = 5;
  localparam logic [PREFIX_W-1:0] MCODE_PREFIX = 5'b00001;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_RS_LO,
    ST_RS_HI,
    ST_RS_SDA,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_HOLD,
    ST_STOP_LO,
    ST_STOP_HI,
    ST_STOP_REL
  } seq_state_e;
endpackage

// File: rtl/i2c_hs_code_chk.sv
module i2c_hs_code_chk
  import i2c_hs_pkg::*;
(
  input  logic [BYTE_W-1:0] code_i,
  output logic              ok_o
);
  assign ok_o = (code_i[BYTE_W-1 -: PREFIX_W] == MCODE_PREFIX);
endmodule

// File: rtl/i2c_hs_timer.sv
module i2c_hs_timer
  import i2c_hs_pkg::*;
#(
  parameter int TPR_W   = 8,
  parameter int CNT_W   = 14,
  parameter int SLOW_LP = 6,
  parameter int SLOW_HP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_sel_i,
  input  logic [TPR_W-1:0] tpr_i,
  input  logic [TPR_W-1:0] hs_tpr_i,
  input  logic             load_i,
  input  logic             high_i,
  output logic             done_o
);
  logic [CNT_W-1:0] unit_len, lp_units, hp_units, phase_len, cnt_q;

  always_comb begin
    unit_len  = (CNT_W'(hs_sel_i ? hs_tpr_i : tpr_i) + CNT_W'(1)) << 1;
    lp_units  = hs_sel_i ? CNT_W'(HS_LP) : CNT_W'(SLOW_LP);
    hp_units  = hs_sel_i ? CNT_W'(HS_HP) : CNT_W'(SLOW_HP);
    phase_len = unit_len * (high_i ? hp_units : lp_units);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= phase_len - CNT_W'(1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_hs_seq.sv
module i2c_hs_seq
  import i2c_hs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_start_i,
  input  logic              cmd_stop_i,
  input  logic              cmd_hs_i,
  input  logic              cmd_burst_i,
  input  logic              cmd_read_i,
  input  logic              cmd_ack_i,
  input  logic [BYTE_W-1:0] cmd_data_i,
  input  logic              code_ok_i,
  input  logic              sda_i,
  input  logic              tmr_done_i,
  output logic              tmr_load_o,
  output logic              tmr_high_o,
  output logic              hs_mode_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              ready_o,
  output logic              busy_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              nack_o,
  output logic              code_err_o,
  output logic              proto_err_o
);
  localparam int IDX_W = $clog2(BYTE_W + 1);
  localparam logic [IDX_W-1:0] ACK_IDX = IDX_W'(BYTE_W);

  seq_state_e state_q, state_d;
  logic [IDX_W-1:0]  bit_idx_q;
  logic [BYTE_W-1:0] sh_q, rx_q;
  logic is_code_q, rd_q, ack_en_q, stop_q, hs_q, rs_pend_q, single_q;
  logic nack_q, code_err_q, proto_err_q;
  logic accept, reject, bit_drv, last_bit;

  assign ready_o  = (state_q == ST_IDLE) || (state_q == ST_HOLD);
  assign busy_o   = !ready_o;
  assign accept   = cmd_valid_i && ready_o;
  assign reject   = accept && cmd_hs_i && !code_ok_i;
  assign last_bit = (bit_idx_q == ACK_IDX);
  assign bit_drv  = last_bit ? (rd_q && ack_en_q) : (!rd_q && !sh_q[BYTE_W-1]);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept && !reject) state_d = ST_START;
      ST_HOLD: begin
        if (accept && !reject) begin
          if (cmd_start_i || cmd_hs_i || rs_pend_q) state_d = ST_RS_LO;
          else                                      state_d = ST_BIT_LO;
        end
      end
      ST_START:   if (tmr_done_i) state_d = ST_BIT_LO;
      ST_RS_LO:   if (tmr_done_i) state_d = ST_RS_HI;
      ST_RS_HI:   if (tmr_done_i) state_d = ST_RS_SDA;
      ST_RS_SDA:  if (tmr_done_i) state_d = ST_BIT_LO;
      ST_BIT_LO:  if (tmr_done_i) state_d = ST_BIT_HI;
      ST_BIT_HI: begin
        if (tmr_done_i) begin
          if (!last_bit)                state_d = ST_BIT_LO;
          else if (stop_q && !is_code_q) state_d = ST_STOP_LO;
          else                          state_d = ST_HOLD;
        end
      end
      ST_STOP_LO:  if (tmr_done_i) state_d = ST_STOP_HI;
      ST_STOP_HI:  if (tmr_done_i) state_d = ST_STOP_REL;
      ST_STOP_REL: if (tmr_done_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // timer reload on every entry into a timed phase
  always_comb begin
    tmr_load_o = (state_d != state_q) && (state_d != ST_IDLE) && (state_d != ST_HOLD);
    tmr_high_o = (state_d == ST_START) || (state_d == ST_RS_HI) || (state_d == ST_RS_SDA) ||
                 (state_d == ST_BIT_HI) || (state_d == ST_STOP_HI) || (state_d == ST_STOP_REL);
  end

  always_comb begin
    scl_oe_o = (state_q == ST_RS_LO) || (state_q == ST_BIT_LO) ||
               (state_q == ST_HOLD)  || (state_q == ST_STOP_LO);
    unique case (state_q)
      ST_START, ST_RS_SDA, ST_STOP_LO, ST_STOP_HI: sda_oe_o = 1'b1;
      ST_BIT_LO, ST_BIT_HI:                        sda_oe_o = bit_drv;
      default:                                     sda_oe_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_idx_q   <= '0;
      sh_q        <= '0;
      rx_q        <= '0;
      is_code_q   <= 1'b0;
      rd_q        <= 1'b0;
      ack_en_q    <= 1'b0;
      stop_q      <= 1'b0;
      hs_q        <= 1'b0;
      rs_pend_q   <= 1'b0;
      single_q    <= 1'b0;
      nack_q      <= 1'b0;
      code_err_q  <= 1'b0;
      proto_err_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (reject) begin
        code_err_q <= 1'b1;
      end else if (accept) begin
        code_err_q  <= 1'b0;
        nack_q      <= 1'b0;
        proto_err_q <= 1'b0;
        bit_idx_q   <= '0;
        sh_q        <= cmd_data_i;
        is_code_q   <= cmd_hs_i;
        rd_q        <= cmd_read_i && !cmd_hs_i;
        ack_en_q    <= cmd_ack_i;
        stop_q      <= !cmd_hs_i && (cmd_stop_i || single_q);
        if (cmd_hs_i) single_q <= !cmd_burst_i;
        if (state_d == ST_RS_LO) rs_pend_q <= 1'b0;
      end
      if (state_q == ST_BIT_HI && tmr_done_i) begin
        if (!last_bit) begin
          sh_q      <= sh_q << 1;
          bit_idx_q <= bit_idx_q + IDX_W'(1);
          if (rd_q) rx_q <= {rx_q[BYTE_W-2:0], sda_i};
        end else if (is_code_q) begin
          proto_err_q <= !sda_i;
          hs_q        <= 1'b1;
          rs_pend_q   <= 1'b1;
        end else begin
          nack_q <= !rd_q && sda_i;
        end
      end
      if (state_q == ST_STOP_REL && tmr_done_i) begin
        hs_q      <= 1'b0;
        rs_pend_q <= 1'b0;
        single_q  <= 1'b0;
      end
    end
  end

  assign hs_mode_o   = hs_q;
  assign rx_data_o   = rx_q;
  assign nack_o      = nack_q;
  assign code_err_o  = code_err_q;
  assign proto_err_o = proto_err_q;

  // R2: rejected code leaves the sequencer where it was and flags it
  a_r2_bad_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && ready_o && cmd_hs_i && !code_ok_i) |=> (code_err_o && $stable(state_q)));

  // R5: high-speed mode is entered only at the end of a master code ninth bit
  a_r5_hs_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_q) |-> $past(state_q == ST_BIT_HI && is_code_q && last_bit));

  // R7: high-speed mode ends only when a STOP completes
  a_r7_hs_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_q) |-> $past(state_q == ST_STOP_REL));

  // R13: SCL moves only at a phase end or a command acceptance
  a_r13_scl_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scl_oe_o) |-> $past(tmr_done_i || (cmd_valid_i && ready_o)));

  // R9: a strobe while busy is not taken
  a_r9_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && busy_o && state_q == ST_BIT_LO && !tmr_done_i) |=> (state_q == ST_BIT_LO));
endmodule

// File: rtl/i2c_hs_master.sv
module i2c_hs_master
  import i2c_hs_pkg::*;
#(
  parameter int TPR_W   = 8,
  parameter int SLOW_LP = 6,
  parameter int SLOW_HP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TPR_W-1:0] tpr_i,
  input  logic [TPR_W-1:0] hs_tpr_i,
  input  logic             hs_tpr_en_i,
  input  logic             cmd_valid_i,
  input  logic             cmd_start_i,
  input  logic             cmd_stop_i,
  input  logic             cmd_hs_i,
  input  logic             cmd_burst_i,
  input  logic             cmd_read_i,
  input  logic             cmd_ack_i,
  input  logic [7:0]       cmd_data_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             ready_o,
  output logic             busy_o,
  output logic             hs_mode_o,
  output logic [7:0]       rx_data_o,
  output logic             nack_o,
  output logic             code_err_o,
  output logic             proto_err_o
);
  localparam int CNT_W = TPR_W + 6;

  logic code_ok, tmr_load, tmr_high, tmr_done, hs_sel;

  assign hs_sel = hs_mode_o && hs_tpr_en_i;

  i2c_hs_code_chk u_code_chk (
    .code_i (cmd_data_i),
    .ok_o   (code_ok)
  );

  i2c_hs_timer #(
    .TPR_W   (TPR_W),
    .CNT_W   (CNT_W),
    .SLOW_LP (SLOW_LP),
    .SLOW_HP (SLOW_HP)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hs_sel_i (hs_sel),
    .tpr_i    (tpr_i),
    .hs_tpr_i (hs_tpr_i),
    .load_i   (tmr_load),
    .high_i   (tmr_high),
    .done_o   (tmr_done)
  );

  i2c_hs_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_start_i (cmd_start_i),
    .cmd_stop_i  (cmd_stop_i),
    .cmd_hs_i    (cmd_hs_i),
    .cmd_burst_i (cmd_burst_i),
    .cmd_read_i  (cmd_read_i),
    .cmd_ack_i   (cmd_ack_i),
    .cmd_data_i  (cmd_data_i),
    .code_ok_i   (code_ok),
    .sda_i       (sda_i),
    .tmr_done_i  (tmr_done),
    .tmr_load_o  (tmr_load),
    .tmr_high_o  (tmr_high),
    .hs_mode_o   (hs_mode_o),
    .scl_oe_o    (scl_oe_o),
    .sda_oe_o    (sda_oe_o),
    .ready_o     (ready_o),
    .busy_o      (busy_o),
    .rx_data_o   (rx_data_o),
    .nack_o      (nack_o),
    .code_err_o  (code_err_o),
    .proto_err_o (proto_err_o)
  );
endmodule

// File: tb/tb_i2c_hs_master.sv
module tb_i2c_hs_master;
  localparam int CLK_PERIOD = 10;
  localparam int TPR  = 1;
  localparam int HTPR = 0;
  localparam int SLO = 2 * (TPR + 1) * 6;
  localparam int SHI = 2 * (TPR + 1) * 4;
  localparam int HLO = 2 * (HTPR + 1) * 2;
  localparam int HHI = 2 * (HTPR + 1) * 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_tpr_en = 1'b1;
  logic cmd_valid = 1'b0, cmd_start = 1'b0, cmd_stop = 1'b0, cmd_hs = 1'b0;
  logic cmd_burst = 1'b0, cmd_read = 1'b0, cmd_ack = 1'b0;
  logic [7:0] cmd_data = '0;
  logic scl_oe, sda_oe, ready, busy, hs_mode, nack, code_err, proto_err;
  logic [7:0] rx_data;
  logic slv_pull = 1'b0;
  logic scl_line, sda_line;

  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || slv_pull);

  i2c_hs_master dut (
    .clk_i(clk), .rst_ni(rst_n), .tpr_i(8'(TPR)), .hs_tpr_i(8'(HTPR)),
    .hs_tpr_en_i(hs_tpr_en), .cmd_valid_i(cmd_valid), .cmd_start_i(cmd_start),
    .cmd_stop_i(cmd_stop), .cmd_hs_i(cmd_hs), .cmd_burst_i(cmd_burst),
    .cmd_read_i(cmd_read), .cmd_ack_i(cmd_ack), .cmd_data_i(cmd_data),
    .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .ready_o(ready),
    .busy_o(busy), .hs_mode_o(hs_mode), .rx_data_o(rx_data), .nack_o(nack),
    .code_err_o(code_err), .proto_err_o(proto_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard of expected SCL phase lengths, one item per bit
  int    q_lo[$];
  int    q_hi[$];
  string q_tag[$];

  // slave model and monitor
  int slv_mode = 1;           // 0 ack, 1 nack, 2 supply read byte
  logic [7:0] rd_byte = '0;
  int bitcnt = -1, run = 0, lo_meas = 0, starts = 0;
  logic [8:0] cap = '0, last9 = '0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;

  always @(negedge clk) begin
    if (!rst_n) begin
      bitcnt = -1; run = 0; prev_scl = 1'b1; prev_sda = 1'b1; slv_pull = 1'b0;
    end else begin
      if (scl_line != prev_scl) begin
        if (!scl_line) begin
          if (bitcnt >= 0 && bitcnt <= 8) begin
            if (q_hi.size() == 0) begin
              check(1'b0, "R13 unexpected bit", bitcnt, -1);
            end else begin
              int e_lo, e_hi;
              string tg;
              e_lo = q_lo.pop_front();
              e_hi = q_hi.pop_front();
              tg   = q_tag.pop_front();
              check(run == e_hi, {tg, " scl high"}, run, e_hi);
              if (e_lo >= 0) check(lo_meas == e_lo, {tg, " scl low"}, lo_meas, e_lo);
            end
          end
          bitcnt = (bitcnt == 8) ? 0 : bitcnt + 1;
        end else begin
          lo_meas = run;
          if (bitcnt >= 0 && bitcnt <= 8) cap = {cap[7:0], sda_line};
          if (bitcnt == 8) last9 = cap;
        end
        run = 1;
      end else begin
        run++;
      end
      if (scl_line && prev_scl && (sda_line != prev_sda)) begin
        if (!sda_line) starts++;
        bitcnt = -1;
      end
      prev_scl = scl_line;
      prev_sda = sda_line;
      if (slv_mode == 2 && bitcnt >= 0 && bitcnt <= 7) slv_pull = !rd_byte[7 - bitcnt];
      else slv_pull = (slv_mode == 0 && bitcnt == 8);
    end
  end

  task automatic pulse(input bit st, sp, hs, bu, rd, ak, input logic [7:0] d);
    @(negedge clk);
    cmd_start = st; cmd_stop = sp; cmd_hs = hs; cmd_burst = bu;
    cmd_read = rd; cmd_ack = ak; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // driver: push expected per-bit lengths, issue command, wait for completion
  task automatic send(input bit st, sp, hs, bu, rd, ak, input logic [7:0] d,
                      input int lo, hi, input string tag, input int mode,
                      input logic [7:0] rdb, input bit stray);
    slv_mode = mode;
    rd_byte  = rdb;
    for (int i = 0; i < 9; i++) begin
      q_lo.push_back(i == 0 ? -1 : lo);
      q_hi.push_back(hi);
      q_tag.push_back(tag);
    end
    pulse(st, sp, hs, bu, rd, ak, d);
    if (stray) begin
      repeat (10) @(negedge clk);
      check(busy == 1'b1, "R9 busy during byte", int'(busy), 1);
      pulse(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF);
    end
    while (!ready) @(negedge clk);
    repeat (2) @(negedge clk);
    check(q_hi.size() == 0, {tag, " all bits seen"}, q_hi.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(scl_oe == 0 && sda_oe == 0, "R1 lines released", {scl_oe, sda_oe}, 0);
    check(ready == 1 && busy == 0, "R1 ready", {ready, busy}, 2);
    check(hs_mode == 0 && nack == 0 && code_err == 0 && proto_err == 0,
          "R1 flags", {hs_mode, nack, code_err, proto_err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 codes outside 00001xxx are rejected
    pulse(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h10);
    @(negedge clk);
    check(code_err == 1, "R2 reject 0x10", code_err, 1);
    check(ready == 1 && scl_oe == 0 && sda_oe == 0, "R2 no bus activity",
          {ready, scl_oe, sda_oe}, 4);
    pulse(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h07);
    @(negedge clk);
    check(code_err == 1 && ready == 1, "R2 reject 0x07", {code_err, ready}, 3);

    // R3 R4 burst launch, code at slow rate, NACK expected
    s0 = starts;
    send(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h09, SLO, SHI, "R3 code", 1, 8'h00, 1'b0);
    check(code_err == 0, "R2 cleared on accept", code_err, 0);
    check(proto_err == 0, "R4 nack gives no error", proto_err, 0);
    check(hs_mode == 1, "R5 hs mode entered", hs_mode, 1);
    check(last9 == {8'h09, 1'b1}, "R3 code on bus", last9, {8'h09, 1'b1});
    check(starts == s0 + 1, "R3 one start", starts, s0 + 1);

    // R5 first high-speed byte: automatic repeated START
    send(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA4, HLO, HHI, "R5 hs byte", 0, 8'h00, 1'b0);
    check(starts == s0 + 2, "R5 repeated start", starts, s0 + 2);
    check(last9 == {8'hA4, 1'b0}, "R5 byte on bus", last9, {8'hA4, 1'b0});
    check(nack == 0, "R11 ack clears nack", nack, 0);

    // R6 R9 later byte stays fast; stray strobe ignored
    send(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, HLO, HHI, "R6 hs byte", 0, 8'h00, 1'b1);
    check(last9[8:1] == 8'h3C, "R9 byte unchanged", last9[8:1], 8'h3C);
    check(starts == s0 + 2, "R9 no extra start", starts, s0 + 2);
    check(hs_mode == 1, "R6 still high speed", hs_mode, 1);

    // R10 reads with and without ack
    send(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, HLO, HHI, "R10 read ack", 2, 8'h5A, 1'b0);
    check(rx_data == 8'h5A, "R10 rx data", rx_data, 8'h5A);
    check(last9[0] == 1'b0, "R10 master ack", last9[0], 0);
    send(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, HLO, HHI, "R10 read nack", 2, 8'h96, 1'b0);
    check(rx_data == 8'h96, "R10 rx data 2", rx_data, 8'h96);
    check(last9[0] == 1'b1, "R10 master nack", last9[0], 1);
    check(hs_mode == 0, "R7 stop leaves hs", hs_mode, 0);
    check(scl_oe == 0 && sda_oe == 0, "R7 bus released", {scl_oe, sda_oe}, 0);

    // R7 R11 new transaction back at slow rate, slave NACKs
    s0 = starts;
    send(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h50, SLO, SHI, "R7 slow byte", 1, 8'h00, 1'b0);
    check(nack == 1, "R11 nack flagged", nack, 1);
    check(starts == s0 + 1, "R7 start", starts, s0 + 1);
    check(hs_mode == 0, "R7 hs off", hs_mode, 0);

    // R4 R8 R12 single launch, code acknowledged, hs period disabled
    hs_tpr_en = 1'b0;
    send(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0F, SLO, SHI, "R4 acked code", 0, 8'h00, 1'b0);
    check(proto_err == 1, "R4 ack flagged", proto_err, 1);
    check(hs_mode == 1, "R12 hs entered", hs_mode, 1);
    send(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11, SLO, SHI, "R8 slow hs byte", 0, 8'h00, 1'b0);
    check(hs_mode == 0, "R12 auto stop", hs_mode, 0);
    check(scl_oe == 0 && sda_oe == 0 && ready == 1, "R12 bus free",
          {scl_oe, sda_oe, ready}, 1);
    check(last9[8:1] == 8'h11, "R12 byte on bus", last9[8:1], 8'h11);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule